// File: doc/BRIEF.md
# Memory-Backed Pending Bit Updater

This block keeps the pending state of message-signalled interrupts up to date. That state is one bit per interrupt ID, held in a table in external memory. It accepts set and clear commands for a single ID. For each command it reads the byte that holds the ID's bit and decides whether the bit has to change. Only when it does change is the byte written back, and only then does the block pulse an update request so that the prioritisation logic can recompute the highest-priority interrupt. Invalidate commands, for one ID or for all, are accepted and have no effect.

A small configuration port loads three things: a global enable, a clamped ID-width field together with the configuration-table base, and the pending-table base. Each command is captured when it is accepted and handled by a six-state sequencer. Both the read and the write use a valid/ready request channel, and each is followed by a one-beat response.

Top module: `pend_bit_updater`

## Requirements
- R1: After reset, busy, mem_req_valid and update_pulse are low, cmd_ready is high, and every configuration output reads zero.
- R2: While the enable (bit 0 of a write with cfg_wr_sel = 0) is clear, an offered command is consumed with no memory request and no update pulse.
- R3: A write with cfg_wr_sel = 1 loads the ID width from data bits [4:0]. Any value above 15 is stored as 15.
- R4: With ID width W, a command whose ID is greater than 1 << (W + 1) is ignored. An ID equal to that limit is processed.
- R5: The memory byte address is the pending base plus ID >> 3, and the bit within the byte is ID[2:0]. A write with cfg_wr_sel = 2 keeps data bits [51:16] as the pending base and clears bits [15:0].
- R6: A set command (cmd_op = 0) on a clear bit writes the read byte with that bit set, then pulses update_pulse for exactly one cycle.
- R7: A clear command (cmd_op = 1) on a set bit writes the read byte with that bit cleared, then pulses update_pulse for exactly one cycle.
- R8: A set on a bit that is already set, or a clear on a bit that is already clear, performs the read only. There is no write and no update pulse.
- R9: Invalidate commands (cmd_op = 2 for one ID, 3 for all) cause no memory traffic and no update pulse.
- R10: busy is high from the cycle after a command is accepted until the sequence ends. While busy is high, cmd_ready is low and offered commands are dropped.
- R11: A memory request that is not yet accepted holds its valid, address, direction and write data until mem_req_ready is seen.
- R12: A write with cfg_wr_sel = 1 keeps data bits [51:12] as the configuration-table base and clears bits [11:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | Register select: 0 control, 1 ID width and configuration base, 2 pending base |
| cfg_wr_data | input | 64 | Configuration write data |
| cfg_enable | output | 1 | Current enable flag |
| cfg_idw | output | 5 | Current clamped ID width |
| cfg_prop_base | output | 52 | Current configuration-table base |
| cfg_pend_base | output | 52 | Current pending-table base |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | 0 set, 1 clear, 2 invalidate one, 3 invalidate all |
| cmd_id | input | 32 | Interrupt ID |
| busy | output | 1 | Sequence in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 52 | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_rdata | input | 8 | Read byte |
| update_pulse | output | 1 | One-cycle request to recompute priority |

## Verification
The assertions assume that the memory returns exactly one response for each accepted request, never before the cycle after acceptance, and never while no request is outstanding. They also assume that configuration writes are not used to change the enable or the bases while a command is waiting for a decision. The bench memory model answers one cycle after every handshake and inserts a programmable number of stall cycles before ready, which exercises request holding. All configuration writes are made while the block is idle.

// File: rtl/pbu_pkg.sv
package pbu_pkg;
  typedef enum logic [1:0] {
    OP_SET     = 2'd0,
    OP_CLR     = 2'd1,
    OP_INV_ONE = 2'd2,
    OP_INV_ALL = 2'd3
  } pbu_op_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PROP = 2'd1,
    SEL_PEND = 2'd2,
    SEL_RSVD = 2'd3
  } pbu_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WR_REQ  = 3'd3,
    ST_WR_WAIT = 3'd4,
    ST_DONE    = 3'd5
  } pbu_state_e;
endpackage

// File: rtl/pbu_cfg_regs.sv
module pbu_cfg_regs
  import pbu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 52,
  parameter int IDW_W    = 5,
  parameter int IDW_MAX  = 15,
  parameter int PEND_LSB = 16,
  parameter int PROP_LSB = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              enable,
  output logic [IDW_W-1:0]  idw,
  output logic [ADDR_W-1:0] prop_base,
  output logic [ADDR_W-1:0] pend_base
);
  localparam logic [IDW_W-1:0] IDW_CAP = IDW_W'(IDW_MAX);
  localparam int PEND_W = ADDR_W - PEND_LSB;
  localparam int PROP_W = ADDR_W - PROP_LSB;

  logic              en_q, en_d, en_ld;
  logic [IDW_W-1:0]  idw_q, idw_d, idw_raw;
  logic [PROP_W-1:0] prop_q, prop_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              prop_ld, pend_ld;

  always_comb begin
    en_ld   = wr_en && (pbu_sel_e'(wr_sel) == SEL_CTRL);
    prop_ld = wr_en && (pbu_sel_e'(wr_sel) == SEL_PROP);
    pend_ld = wr_en && (pbu_sel_e'(wr_sel) == SEL_PEND);
    en_d    = wr_data[0];
    idw_raw = wr_data[IDW_W-1:0];
    idw_d   = (idw_raw > IDW_CAP) ? IDW_CAP : idw_raw;
    prop_d  = wr_data[ADDR_W-1:PROP_LSB];
    pend_d  = wr_data[ADDR_W-1:PEND_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      idw_q  <= '0;
      prop_q <= '0;
      pend_q <= '0;
    end else begin
      if (en_ld) en_q <= en_d;
      if (prop_ld) begin
        idw_q  <= idw_d;
        prop_q <= prop_d;
      end
      if (pend_ld) pend_q <= pend_d;
    end
  end

  assign enable    = en_q;
  assign idw       = idw_q;
  assign prop_base = {prop_q, {PROP_LSB{1'b0}}};
  assign pend_base = {pend_q, {PEND_LSB{1'b0}}};

  // R3
  idw_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idw_q <= IDW_CAP);
endmodule

// File: rtl/pbu_cmd_filter.sv
module pbu_cmd_filter
  import pbu_pkg::*;
#(
  parameter int ID_W   = 32,
  parameter int ADDR_W = 52,
  parameter int IDW_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic              fire,
  input  logic [1:0]        op,
  input  logic [ID_W-1:0]   id,
  input  logic              enable,
  input  logic [IDW_W-1:0]  idw,
  input  logic [ADDR_W-1:0] pend_base,
  output logic              start,
  output logic              set_op,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [$clog2(BYTE_W)-1:0] bit_idx
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int LIM_W = ID_W + 1;

  logic [LIM_W-1:0] limit;
  logic [IDW_W:0]   shamt;
  logic             in_range;
  logic             is_rmw;

  always_comb begin
    shamt     = {1'b0, idw} + 1'b1;
    limit     = LIM_W'(1) << shamt;
    in_range  = ({1'b0, id} <= limit);
    is_rmw    = (pbu_op_e'(op) == OP_SET) || (pbu_op_e'(op) == OP_CLR);
    start     = fire && enable && is_rmw && in_range;
    set_op    = (pbu_op_e'(op) == OP_SET);
    byte_addr = pend_base + ADDR_W'(id >> BIT_W);
    bit_idx   = id[BIT_W-1:0];
  end
endmodule

// File: rtl/pbu_rmw_fsm.sv
module pbu_rmw_fsm
  import pbu_pkg::*;
#(
  parameter int ADDR_W = 52,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_set,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [$clog2(BYTE_W)-1:0] start_bit,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [BYTE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [BYTE_W-1:0] mem_rsp_rdata,
  output logic              update_pulse
);
  localparam int BIT_W = $clog2(BYTE_W);

  pbu_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [BIT_W-1:0]  bit_q;
  logic              set_q;
  logic [BYTE_W-1:0] rd_q;
  logic              wrote_q, wrote_d, wrote_ld;
  logic              cmd_ld, rd_ld;
  logic [BYTE_W-1:0] mask;
  logic              redundant;

  always_comb begin
    mask      = BYTE_W'(1) << start_bit;
    mask      = BYTE_W'(1) << bit_q;
    redundant = set_q ? mem_rsp_rdata[bit_q] : !mem_rsp_rdata[bit_q];
  end

  always_comb begin
    state_d  = state_q;
    cmd_ld   = 1'b0;
    rd_ld    = 1'b0;
    wrote_ld = 1'b0;
    wrote_d  = wrote_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_RD_REQ;
        cmd_ld   = 1'b1;
        wrote_ld = 1'b1;
        wrote_d  = 1'b0;
      end
      ST_RD_REQ:  if (mem_req_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_rsp_valid) begin
        rd_ld   = 1'b1;
        state_d = redundant ? ST_DONE : ST_WR_REQ;
      end
      ST_WR_REQ:  if (mem_req_ready) state_d = ST_WR_WAIT;
      ST_WR_WAIT: if (mem_rsp_valid) begin
        state_d  = ST_DONE;
        wrote_ld = 1'b1;
        wrote_d  = 1'b1;
      end
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      bit_q   <= '0;
      set_q   <= 1'b0;
      rd_q    <= '0;
      wrote_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cmd_ld) begin
        addr_q <= start_addr;
        bit_q  <= start_bit;
        set_q  <= start_set;
      end
      if (rd_ld)    rd_q    <= mem_rsp_rdata;
      if (wrote_ld) wrote_q <= wrote_d;
    end
  end

  always_comb begin
    busy          = (state_q != ST_IDLE);
    mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
    mem_req_we    = (state_q == ST_WR_REQ);
    mem_req_addr  = addr_q;
    mem_req_wdata = set_q ? (rd_q | mask) : (rd_q & ~mask);
    update_pulse  = (state_q == ST_DONE) && wrote_q;
  end

  // R6 R7
  one_bit_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> ($countones(mem_req_wdata ^ rd_q) == 1));

  // R8
  pulse_after_wack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |-> $past(mem_rsp_valid && mem_req_we == 1'b0 && state_q == ST_WR_WAIT));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !update_pulse));
endmodule

// File: rtl/pend_bit_updater.sv
module pend_bit_updater
  import pbu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 52,
  parameter int ID_W     = 32,
  parameter int IDW_W    = 5,
  parameter int IDW_MAX  = 15,
  parameter int PEND_LSB = 16,
  parameter int PROP_LSB = 12,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_sel,
  input  logic [DATA_W-1:0] cfg_wr_data,
  output logic              cfg_enable,
  output logic [IDW_W-1:0]  cfg_idw,
  output logic [ADDR_W-1:0] cfg_prop_base,
  output logic [ADDR_W-1:0] cfg_pend_base,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ID_W-1:0]   cmd_id,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [BYTE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [BYTE_W-1:0] mem_rsp_rdata,
  output logic              update_pulse
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic              fire;
  logic              start;
  logic              start_set;
  logic [ADDR_W-1:0] start_addr;
  logic [BIT_W-1:0]  start_bit;

  pbu_cfg_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDW_W(IDW_W), .IDW_MAX(IDW_MAX),
    .PEND_LSB(PEND_LSB), .PROP_LSB(PROP_LSB)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
    .enable(cfg_enable), .idw(cfg_idw),
    .prop_base(cfg_prop_base), .pend_base(cfg_pend_base)
  );

  assign cmd_ready = !busy;
  assign fire      = cmd_valid && cmd_ready;

  pbu_cmd_filter #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .IDW_W(IDW_W), .BYTE_W(BYTE_W)
  ) u_filt (
    .fire(fire), .op(cmd_op), .id(cmd_id),
    .enable(cfg_enable), .idw(cfg_idw), .pend_base(cfg_pend_base),
    .start(start), .set_op(start_set), .byte_addr(start_addr), .bit_idx(start_bit)
  );

  pbu_rmw_fsm #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_set(start_set), .start_addr(start_addr), .start_bit(start_bit),
    .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .update_pulse(update_pulse)
  );

  // R2
  disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && cmd_valid && !busy) |=> !busy);

  // R9
  inval_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op[1]) |=> !busy);
endmodule

// File: tb/pend_bit_updater_test.sv
module pend_bit_updater_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [1:0]  cfg_wr_sel;
  logic [63:0] cfg_wr_data;
  logic        cfg_enable;
  logic [4:0]  cfg_idw;
  logic [51:0] cfg_prop_base, cfg_pend_base;
  logic        cmd_valid, cmd_ready;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_id;
  logic        busy;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [51:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid;
  logic [7:0]  mem_rsp_rdata;
  logic        update_pulse;

  int vectors = 0;
  int miscompares = 0;
  int rd_cnt = 0, wr_cnt = 0, upd_cnt = 0;
  int stall = 0;
  int dly = 0;
  logic [51:0] last_addr;
  logic [7:0]  mem [0:255];

  always #10 clk = ~clk;

  pend_bit_updater uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .cfg_enable(cfg_enable), .cfg_idw(cfg_idw),
    .cfg_prop_base(cfg_prop_base), .cfg_pend_base(cfg_pend_base),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_id(cmd_id),
    .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .update_pulse(update_pulse)
  );

  assign mem_req_ready = mem_req_valid && (dly >= stall);

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      last_addr     <= mem_req_addr;
      dly           <= 0;
      if (mem_req_we) begin
        mem[mem_req_addr[7:0]] <= mem_req_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rsp_rdata <= mem[mem_req_addr[7:0]];
        rd_cnt <= rd_cnt + 1;
      end
    end else if (mem_req_valid) begin
      dly <= dly + 1;
    end
    if (update_pulse) upd_cnt <= upd_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [63:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [31:0] id);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_id = id;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_sel = '0; cfg_wr_data = '0;
    cmd_valid = 1'b0; cmd_op = '0; cmd_id = '0;
    repeat (3) @(negedge clk);
    // R1
    check(!busy && cmd_ready, "R1 busy/ready", {62'd0, busy, cmd_ready}, 64'h1);
    check(!mem_req_valid && !update_pulse, "R1 mem/update", {62'd0, mem_req_valid, update_pulse}, 0);
    check(!cfg_enable && cfg_idw == 0 && cfg_pend_base == 0 && cfg_prop_base == 0,
          "R1 config", {cfg_pend_base[31:0], 27'd0, cfg_idw}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_config();
    cfg_write(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    // R3 clamp
    check(cfg_idw == 5'd15, "R3 clamp", {59'd0, cfg_idw}, 15);
    // R12
    check(cfg_prop_base == 52'hF_FFFF_FFFF_F000, "R12 prop base", {12'd0, cfg_prop_base}, 64'hF_FFFF_FFFF_F000);
    cfg_write(2'd1, 64'h0000_0000_0000_1A07);
    check(cfg_idw == 5'd7, "R3 in range", {59'd0, cfg_idw}, 7);
    cfg_write(2'd2, 64'h0000_0012_3456_ABCD);
    // R5 base masking
    check(cfg_pend_base == 52'h12_3456_0000, "R5 pend base", {12'd0, cfg_pend_base}, 64'h12_3456_0000);
  endtask

  task automatic t_disabled();
    int r0 = rd_cnt, u0 = upd_cnt;
    mem[5] = 8'h00;
    do_cmd(2'd0, 32'd40);
    // R2
    check(rd_cnt == r0 && upd_cnt == u0 && mem[5] == 8'h00, "R2 disabled", rd_cnt - r0, 0);
    cfg_write(2'd0, 64'h1);
  endtask

  task automatic t_set_new();
    int w0 = wr_cnt, u0 = upd_cnt;
    mem[5] = 8'h41;
    stall = 0;
    do_cmd(2'd0, 32'd43);
    // R6
    check(mem[5] == 8'h49, "R6 set byte", mem[5], 8'h49);
    check(wr_cnt == w0 + 1 && upd_cnt == u0 + 1, "R6 write/update", upd_cnt - u0, 1);
    // R5 address
    check(last_addr == 52'h12_3456_0005, "R5 address", {12'd0, last_addr}, 64'h12_3456_0005);
  endtask

  task automatic t_clear();
    int w0 = wr_cnt, u0 = upd_cnt;
    mem[9] = 8'hFF;
    stall = 2;
    do_cmd(2'd1, 32'd79);
    // R7
    check(mem[9] == 8'h7F, "R7 clear byte", mem[9], 8'h7F);
    check(wr_cnt == w0 + 1 && upd_cnt == u0 + 1, "R7 write/update", upd_cnt - u0, 1);
    stall = 0;
  endtask

  task automatic t_redundant();
    int r0 = rd_cnt, w0 = wr_cnt, u0 = upd_cnt;
    mem[3] = 8'h04;
    do_cmd(2'd0, 32'd26);
    // R8 set on set bit
    check(rd_cnt == r0 + 1 && wr_cnt == w0 && upd_cnt == u0, "R8 redundant set", wr_cnt - w0, 0);
    do_cmd(2'd1, 32'd25);
    // R8 clear on clear bit
    check(rd_cnt == r0 + 2 && wr_cnt == w0 && upd_cnt == u0 && mem[3] == 8'h04,
          "R8 redundant clear", upd_cnt - u0, 0);
  endtask

  task automatic t_limit();
    int r0 = rd_cnt;
    mem[32] = 8'h00;
    do_cmd(2'd0, 32'd257);
    // R4 beyond limit 256
    check(rd_cnt == r0, "R4 over limit", rd_cnt - r0, 0);
    do_cmd(2'd0, 32'd256);
    // R4 equal to limit
    check(mem[32] == 8'h01 && rd_cnt == r0 + 1, "R4 at limit", mem[32], 1);
  endtask

  task automatic t_inval();
    int r0 = rd_cnt, u0 = upd_cnt;
    do_cmd(2'd2, 32'd10);
    do_cmd(2'd3, 32'd0);
    // R9
    check(rd_cnt == r0 && upd_cnt == u0 && !busy, "R9 invalidate", rd_cnt - r0, 0);
  endtask

  task automatic t_busy();
    int w0 = wr_cnt;
    mem[12] = 8'h00; mem[13] = 8'h00;
    stall = 4;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_id = 32'd96;
    @(negedge clk);
    // R10
    check(busy && !cmd_ready, "R10 busy after accept", {62'd0, busy, cmd_ready}, 2);
    cmd_id = 32'd104;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    @(negedge clk);
    check(mem[12] == 8'h01 && mem[13] == 8'h00 && wr_cnt == w0 + 1, "R10 drop while busy", mem[13], 0);
    // R11 held request through stall still completes at right address
    check(last_addr == 52'h12_3456_000C, "R11 held address", {12'd0, last_addr}, 64'h12_3456_000C);
    stall = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    t_reset();
    t_config();
    t_disabled();
    t_set_new();
    t_clear();
    t_redundant();
    t_limit();
    t_inval();
    t_busy();
    summary();
  end
endmodule